// File: doc/BRIEF.md
# Overcurrent Alarm Event Filter

This block watches a single external overcurrent alarm line. The line is first brought into the local clock domain through a two-stage synchronizer. A configuration bit then selects which level of the line counts as "alarm active". Every change from inactive to active is one alarm event.

Events are counted. Once the count reaches a programmed threshold, a sticky interrupt flag is set and the count starts again from zero. The interrupt is only produced when the threshold is enabled. An inactivity filter clears the count if no new event arrives within a programmed number of clock cycles, so that rare, isolated alarms never add up to an interrupt.

Separately, the block drives a throttle request. The request is high while the alarm is active and stays high for a programmed number of microseconds after the alarm goes away. A clocks-per-microsecond setting scales that hold time. Downstream logic uses the request to slow the clocks it feeds.

Top module: `oc_alarm_filter`

## Requirements
- R1: The raw alarm goes through a two-flop synchronizer. With `cfg_active_low`=1 a low level is the active state; with 0 a high level is. Reset loads the synchronizer with the inactive level. As a result, an alarm that is already active when reset is released is counted as one event.
- R2: With `cfg_thresh_en`=1, each event adds one to the count. When an event brings the count to `cfg_thresh`, meaning count+1 >= `cfg_thresh`, `irq` is set and the count returns to 0. A threshold of 0 or 1 therefore sets `irq` on every event.
- R3: With `cfg_thresh_en`=0, `irq` never becomes set. Events still add to the count, which saturates at its maximum. If the threshold is enabled later, the count held at that point is used.
- R4: `irq` stays set until a cycle in which `irq_clr`=1. If an event sets `irq` in that same cycle, setting wins.
- R5: With `cfg_filter_len`=L and L>0: if L clock cycles pass after the cycle in which an event was counted, with no further event, the count is cleared. An event that arrives exactly L cycles later is still counted on top of the previous count. L=0 turns clearing off.
- R6: `throttle_req` is high while the synchronized alarm is active. After the alarm deactivates, it stays high for `cfg_hold_us`×max(`cfg_clk_per_us`,1) extra cycles. If the alarm reactivates during the hold, the hold starts over at the next deactivation.
- R7: Latency. Call the first rising edge that samples a new raw level edge 1. Then `throttle_req` rises after edge 2, an event sets `irq` after edge 3, and `throttle_req` falls after edge 3 + `cfg_hold_us`×max(`cfg_clk_per_us`,1).
- R8: After reset, `irq`=0, `throttle_req`=0 and the event count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alarm_raw | input | 1 | Unsynchronized overcurrent alarm line |
| cfg_active_low | input | 1 | 1: a low level on the line is active |
| cfg_thresh_en | input | 1 | Enables interrupt generation |
| cfg_thresh | input | CNT_W | Event count that sets the interrupt |
| cfg_filter_len | input | FILT_W | Inactivity filter length in cycles, 0 = off |
| cfg_hold_us | input | HOLD_W | Throttle hold after deassertion, in microseconds |
| cfg_clk_per_us | input | PRE_W | Clock cycles per microsecond, 0 is treated as 1 |
| irq_clr | input | 1 | Clear pulse for the sticky interrupt |
| irq | output | 1 | Sticky interrupt flag |
| throttle_req | output | 1 | Throttle request |

## Verification
Every result has a fixed delay after the raw line changes. Throttle rises two edges after the change, and the interrupt appears three edges after it. Throttle falls three edges plus the hold length after the line returns to idle. The bench drives on falling edges and samples on falling edges. It checks the interrupt no earlier than three falling edges after each pulse starts, and it counts throttle-high samples from the deassertion onward to compare with 2 + hold cycles. Filter spacings are swept on both sides of the filter length, including exactly equal to it, so that the one-cycle boundary between "counted" and "cleared" is checked.

// File: rtl/oc_pkg.sv
// Package: shared types for the overcurrent alarm filter.
// Assumes: nothing beyond being compiled before its users.
package oc_pkg;

    // Phases of the throttle hold sequencer.
    typedef enum logic [1:0] {
        HOLD_IDLE = 2'd0,
        HOLD_ON   = 2'd1,
        HOLD_TAIL = 2'd2
    } hold_phase_e;

endpackage

// File: rtl/oc_alarm_sync.sv
// Module: oc_alarm_sync
// Brings the raw alarm line into the clock domain, applies the polarity
// setting and produces the active level plus a one-cycle event pulse on
// each inactive-to-active transition.
// Assumes: cfg_active_low is quasi-static; it is sampled as reset value.
module oc_alarm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alarm_raw,
    input  logic cfg_active_low,
    output logic alarm_active,
    output logic alarm_event,
    output logic alarm_release
);

    logic [STAGES-1:0] sync_q;
    logic              active_q;

    // Synchronizer chain; reset loads the inactive level for this polarity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {STAGES{cfg_active_low}};
        end else begin
            sync_q <= {sync_q[STAGES-2:0], alarm_raw};
        end
    end

    assign alarm_active = sync_q[STAGES-1] ^ cfg_active_low;

    // Previous active level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
        end else begin
            active_q <= alarm_active;
        end
    end

    assign alarm_event   = alarm_active & ~active_q;
    assign alarm_release = ~alarm_active & active_q;

endmodule

// File: rtl/oc_event_counter.sv
// Module: oc_event_counter
// Counts alarm events, raises a sticky interrupt when the count reaches the
// threshold (then restarts), and clears the count through an inactivity
// filter timer that every event reloads.
// Assumes: alarm_event is a single-cycle pulse; thresholds are static
// while events arrive.
module oc_event_counter #(
    parameter int CNT_W  = 8,
    parameter int FILT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_event,
    input  logic              cfg_thresh_en,
    input  logic [CNT_W-1:0]  cfg_thresh,
    input  logic [FILT_W-1:0] cfg_filter_len,
    input  logic              irq_clr,
    output logic              irq
);

    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [FILT_W-1:0] FILT_ONE = {{(FILT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0]  count_q;
    logic [CNT_W:0]    count_inc;
    logic [FILT_W-1:0] idle_q;
    logic              fire;
    logic              expire;
    logic              irq_q;

    assign count_inc = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};
    assign fire      = alarm_event & cfg_thresh_en &
                       (count_inc >= {1'b0, cfg_thresh});
    assign expire    = (cfg_filter_len != '0) &&
                       (idle_q == cfg_filter_len - FILT_ONE);

    // Event count: restart on fire, clear on filter expiry, else saturate up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (alarm_event) begin
            if (fire) begin
                count_q <= '0;
            end else if (count_q != CNT_MAX) begin
                count_q <= count_inc[CNT_W-1:0];
            end
        end else if (expire) begin
            count_q <= '0;
        end
    end

    // Inactivity timer: reloaded by each event, rearmed when it expires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (alarm_event || expire) begin
            idle_q <= '0;
        end else if (cfg_filter_len != '0) begin
            idle_q <= idle_q + FILT_ONE;
        end
    end

    // Sticky interrupt; a new fire wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (fire) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/oc_hold_timer.sv
// Module: oc_hold_timer
// Keeps the throttle request high while the alarm is active and for a
// programmed number of microseconds after it deactivates, using a
// prescaler that divides the clock down to one tick per microsecond.
// Assumes: cfg_clk_per_us of 0 is treated as 1.
module oc_hold_timer
    import oc_pkg::*;
#(
    parameter int HOLD_W = 8,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_active,
    input  logic              alarm_release,
    input  logic [HOLD_W-1:0] cfg_hold_us,
    input  logic [PRE_W-1:0]  cfg_clk_per_us,
    output logic              throttle_req
);

    localparam logic [PRE_W-1:0]  PRE_ONE  = {{(PRE_W-1){1'b0}}, 1'b1};
    localparam logic [HOLD_W-1:0] HOLD_ONE = {{(HOLD_W-1){1'b0}}, 1'b1};

    hold_phase_e       phase_q;
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  pre_div;
    logic [HOLD_W-1:0] us_q;
    logic              us_tick;

    assign pre_div = (cfg_clk_per_us == '0) ? PRE_ONE : cfg_clk_per_us;
    assign us_tick = (pre_q == pre_div - PRE_ONE);

    // Phase sequencer: idle, alarm on, post-release hold tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= HOLD_IDLE;
        end else begin
            unique case (phase_q)
                HOLD_IDLE: if (alarm_active) phase_q <= HOLD_ON;
                HOLD_ON: begin
                    if (alarm_release || !alarm_active) begin
                        phase_q <= (cfg_hold_us == '0) ? HOLD_IDLE : HOLD_TAIL;
                    end
                end
                HOLD_TAIL: begin
                    if (alarm_active) begin
                        phase_q <= HOLD_ON;
                    end else if (us_tick && us_q == HOLD_ONE) begin
                        phase_q <= HOLD_IDLE;
                    end
                end
                default: phase_q <= HOLD_IDLE;
            endcase
        end
    end

    // Prescaler: counts clocks within one microsecond of the hold tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (phase_q != HOLD_TAIL || us_tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_ONE;
        end
    end

    // Microsecond down-counter, loaded when the hold tail begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            us_q <= '0;
        end else if (phase_q == HOLD_ON) begin
            us_q <= cfg_hold_us;
        end else if (phase_q == HOLD_TAIL && us_tick && us_q != '0) begin
            us_q <= us_q - HOLD_ONE;
        end
    end

    assign throttle_req = alarm_active || (phase_q != HOLD_IDLE);

endmodule

// File: rtl/oc_alarm_filter.sv
// Module: oc_alarm_filter (top)
// Overcurrent alarm event filter: synchronizer with polarity, event
// counter with threshold interrupt and inactivity filter, and a throttle
// request with a microsecond hold after the alarm deasserts.
// Assumes: configuration is changed only while the alarm is idle or in reset.
module oc_alarm_filter #(
    parameter int CNT_W  = 8,
    parameter int FILT_W = 16,
    parameter int HOLD_W = 8,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alarm_raw,
    input  logic              cfg_active_low,
    input  logic              cfg_thresh_en,
    input  logic [CNT_W-1:0]  cfg_thresh,
    input  logic [FILT_W-1:0] cfg_filter_len,
    input  logic [HOLD_W-1:0] cfg_hold_us,
    input  logic [PRE_W-1:0]  cfg_clk_per_us,
    input  logic              irq_clr,
    output logic              irq,
    output logic              throttle_req
);

    logic alarm_active;
    logic alarm_event;
    logic alarm_release;

    oc_alarm_sync #(.STAGES(2)) u_sync (
        .clk           (clk),
        .rst_n         (rst_n),
        .alarm_raw     (alarm_raw),
        .cfg_active_low(cfg_active_low),
        .alarm_active  (alarm_active),
        .alarm_event   (alarm_event),
        .alarm_release (alarm_release)
    );

    oc_event_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) u_count (
        .clk           (clk),
        .rst_n         (rst_n),
        .alarm_event   (alarm_event),
        .cfg_thresh_en (cfg_thresh_en),
        .cfg_thresh    (cfg_thresh),
        .cfg_filter_len(cfg_filter_len),
        .irq_clr       (irq_clr),
        .irq           (irq)
    );

    oc_hold_timer #(.HOLD_W(HOLD_W), .PRE_W(PRE_W)) u_hold (
        .clk           (clk),
        .rst_n         (rst_n),
        .alarm_active  (alarm_active),
        .alarm_release (alarm_release),
        .cfg_hold_us   (cfg_hold_us),
        .cfg_clk_per_us(cfg_clk_per_us),
        .throttle_req  (throttle_req)
    );

endmodule

// File: rtl/oc_alarm_filter_chk.sv
// Module: oc_alarm_filter_chk
// Temporal checks on the alarm filter, bound to the top module.
// Assumes: rst_n is low at time zero.
module oc_alarm_filter_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_thresh_en,
    input logic irq_clr,
    input logic irq,
    input logic throttle_req,
    input logic alarm_active,
    input logic alarm_event
);

    AST_EDGE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n)
        alarm_event |=> !alarm_event);                                     // R1
    AST_IRQ_FROM_EVT:  assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(alarm_event));                                // R2
    AST_IRQ_NEEDS_EN:  assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !cfg_thresh_en) |=> !irq);                                // R3
    AST_IRQ_STICKY:    assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);                                        // R4
    AST_CLR_WORKS:     assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !cfg_thresh_en) |=> !irq);                             // R4
    AST_THR_COVERS:    assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm_active) |-> throttle_req);                             // R6
    AST_THR_FALL_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(throttle_req) |-> (!alarm_active && $past(!alarm_active)));  // R7

endmodule

bind oc_alarm_filter oc_alarm_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_thresh_en(cfg_thresh_en),
    .irq_clr      (irq_clr),
    .irq          (irq),
    .throttle_req (throttle_req),
    .alarm_active (alarm_active),
    .alarm_event  (alarm_event)
);

// File: tb/oc_alarm_filter_tb.sv
module oc_alarm_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alarm_raw = 1'b0;
    logic        cfg_active_low = 1'b0;
    logic        cfg_thresh_en = 1'b0;
    logic [7:0]  cfg_thresh = '0;
    logic [15:0] cfg_filter_len = '0;
    logic [7:0]  cfg_hold_us = '0;
    logic [7:0]  cfg_clk_per_us = 8'd1;
    logic        irq_clr = 1'b0;
    logic        irq;
    logic        throttle_req;

    int n_vec = 0;
    int n_err = 0;
    int mcnt  = 0;
    logic eirq = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    oc_alarm_filter u_dut (
        .clk(clk), .rst_n(rst_n), .alarm_raw(alarm_raw),
        .cfg_active_low(cfg_active_low), .cfg_thresh_en(cfg_thresh_en),
        .cfg_thresh(cfg_thresh), .cfg_filter_len(cfg_filter_len),
        .cfg_hold_us(cfg_hold_us), .cfg_clk_per_us(cfg_clk_per_us),
        .irq_clr(irq_clr), .irq(irq), .throttle_req(throttle_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        alarm_raw = cfg_active_low;
        irq_clr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mcnt = 0;
        eirq = 1'b0;
    endtask

    task automatic pulse(input int hi, input int gap);
        alarm_raw = ~cfg_active_low;
        repeat (hi) @(negedge clk);
        alarm_raw = cfg_active_low;
        repeat (gap) @(negedge clk);
    endtask

    task automatic model_event();
        if (cfg_thresh_en && (mcnt + 1 >= int'(cfg_thresh))) begin
            eirq = 1'b1;
            mcnt = 0;
        end else if (mcnt < 255) begin
            mcnt++;
        end
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        eirq = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        @(negedge clk);
        chk("R8 irq after reset", irq, 0);
        chk("R8 throttle after reset", throttle_req, 0);

        // R7 latency of throttle and irq
        cfg_thresh_en = 1'b1; cfg_thresh = 8'd0;
        do_reset();
        repeat (3) @(negedge clk);
        alarm_raw = 1'b1;
        @(negedge clk);
        chk("R7 throttle edge1", throttle_req, 0);
        chk("R7 irq edge1", irq, 0);
        @(negedge clk);
        chk("R7 throttle edge2", throttle_req, 1);
        chk("R7 irq edge2", irq, 0);
        @(negedge clk);
        chk("R7 irq edge3", irq, 1);
        alarm_raw = 1'b0;
        repeat (4) @(negedge clk);

        // R2 / R4 threshold sweep
        cfg_filter_len = '0;
        for (int thr = 0; thr <= 6; thr++) begin
            cfg_thresh = 8'(thr);
            do_reset();
            for (int i = 1; i <= 8; i++) begin
                pulse(1 + (i % 3), 4);
                model_event();
                chk("R2 irq after event", irq, eirq);
                if (eirq) begin
                    if (thr == 3) begin
                        repeat (10) @(negedge clk);
                        chk("R4 irq sticky", irq, 1);
                    end
                    clear_irq();
                    chk("R4 irq cleared", irq, 0);
                end
            end
        end

        // R3 disabled threshold, then enable with accumulated count
        cfg_thresh_en = 1'b0; cfg_thresh = 8'd2;
        do_reset();
        for (int i = 0; i < 10; i++) begin
            pulse(2, 4);
            model_event();
            chk("R3 no irq when disabled", irq, 0);
        end
        cfg_thresh_en = 1'b1; cfg_thresh = 8'd5;
        pulse(1, 4);
        model_event();
        chk("R3 held count used on enable", irq, 1);
        clear_irq();

        // R5 filter spacing sweep around L=8, threshold 3
        cfg_thresh_en = 1'b1; cfg_thresh = 8'd3; cfg_filter_len = 16'd8;
        for (int s = 4; s <= 12; s++) begin
            do_reset();
            repeat (3) pulse(1, s - 1);
            chk("R5 filter spacing", irq, (s <= 8) ? 1 : 0);
        end
        cfg_filter_len = 16'd0;
        do_reset();
        repeat (3) pulse(1, 39);
        chk("R5 filter off", irq, 1);

        // R1 polarity and alarm active at reset
        cfg_active_low = 1'b1; cfg_thresh = 8'd0;
        do_reset();
        repeat (6) @(negedge clk);
        chk("R1 no event after reset active-low", irq, 0);
        chk("R1 no throttle idle active-low", throttle_req, 0);
        pulse(1, 4);
        chk("R1 low pulse counted", irq, 1);
        clear_irq();
        cfg_active_low = 1'b0;
        rst_n = 1'b0;
        alarm_raw = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 alarm active at reset counted", irq, 1);
        alarm_raw = 1'b0;
        repeat (4) @(negedge clk);
        clear_irq();

        // R6 hold sweep
        cfg_thresh_en = 1'b0;
        for (int p = 0; p <= 3; p++) begin
            for (int h = 0; h <= 3; h++) begin
                int highs;
                cfg_clk_per_us = 8'(p);
                cfg_hold_us = 8'(h);
                do_reset();
                alarm_raw = 1'b1;
                repeat (5) @(negedge clk);
                alarm_raw = 1'b0;
                highs = 0;
                for (int j = 0; j < 60; j++) begin
                    @(negedge clk);
                    if (throttle_req) highs++;
                    else break;
                end
                chk("R6 hold length", highs, 2 + h * ((p == 0) ? 1 : p));
            end
        end

        // R6 re-assertion during hold restarts it
        begin
            int highs;
            cfg_clk_per_us = 8'd3; cfg_hold_us = 8'd3;
            do_reset();
            alarm_raw = 1'b1;
            repeat (5) @(negedge clk);
            alarm_raw = 1'b0;
            repeat (5) @(negedge clk);
            alarm_raw = 1'b1;
            repeat (3) @(negedge clk);
            alarm_raw = 1'b0;
            highs = 0;
            for (int j = 0; j < 60; j++) begin
                @(negedge clk);
                if (throttle_req) highs++;
                else break;
            end
            chk("R6 hold restart", highs, 11);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule